// File: doc/BRIEF.md
# Time-Shared Multichannel Interpolating FIR

This block is one interpolation stage of a digital up-converter that carries many complex baseband channels (for example several antennas, each with several carriers, each split into I and Q). All of these real channels arrive on one time-division stream. Each input word carries the index of its channel. A single multiply-accumulate engine serves every channel. Each channel keeps its own delay history in a small RAM. For every accepted input sample, the block produces L polyphase output samples.

Output phase p is formed from the coefficients h[p], h[p+L], h[p+2L] and onward, applied to the newest P = N/L samples of that channel. The accumulator never overflows. The result is rounded half-up and then saturated to the input width. Each output word carries its channel index and phase index. Coefficients live in a register bank that is written through a plain address/data port. The engine takes one tap per clock, so the block lowers its ready flag while it works on a sample. Later stages with other factors (for example 5 or 6) reuse the same module with different parameters.

Top module: `tdm_interp_fir`

## Requirements
- R1: Output phase p of channel c equals the sum over k = 0..P-1 of h[p + k*L] * x_c[n-k]. Here x_c[n] is the newest sample of channel c and P = N/L. Coefficients are signed CW-bit values with CW-1 fractional bits, and samples are signed DW-bit values.
- R2: Each accepted sample yields exactly L outputs. Their out_phase values run 0, 1, .. L-1 in that order. Each output carries out_chan equal to the in_chan of that sample.
- R3: Each channel has its own history. A sample on one channel changes neither the history nor the later outputs of any other channel.
- R4: Before saturation, the full-precision sum S is reduced as floor((S + 2^(CW-2)) / 2^(CW-1)). This rounds half-up, so +0.5 LSB goes to +1 and -0.5 LSB goes to 0.
- R5: A reduced result above 2^(DW-1)-1 is output as 2^(DW-1)-1. A result below -2^(DW-1) is output as -2^(DW-1).
- R6: An input is accepted on a rising edge where in_valid and in_ready are both high. After that edge, in_ready is low for exactly L*P cycles. An in_valid pulse while in_ready is low is ignored.
- R7: A write with coef_we high and coef_addr < N stores coef_data into h[coef_addr] on the next edge. A write with coef_addr >= N changes no coefficient.
- R8: During and after reset, in_ready is high and out_valid is low. Reset also clears every coefficient and every channel history to zero.
- R9: The output of phase p is valid for one cycle, starting at the clock edge (p+1)*P edges after the accepting edge. out_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_chan | input | ceil(log2 C) | Channel index of the input sample |
| in_data | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | ceil(log2 N)+1 | Coefficient index; values >= N are ignored |
| coef_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | Output sample present (one-cycle pulse) |
| out_chan | output | ceil(log2 C) | Channel index of the output |
| out_phase | output | ceil(log2 L) | Polyphase index of the output |
| out_data | output | DW | Rounded, saturated output sample |

## Verification
The assertions assume that in_chan is always below C, and that coefficient writes happen only while in_ready is high, so a filter pass never sees a mix of old and new taps. The stimulus keeps to both rules: every channel index comes from the valid range, and the bench loads coefficients only between samples. When the bench drives in_valid during a busy window, it does so on purpose, with in_ready low, so it can show that those pulses leave no trace in the history.

// File: rtl/tdm_fir_pkg.sv
// Shared definitions for the time-shared interpolating FIR.
// Assumes: callers pass positive counts to bits().
package tdm_fir_pkg;

    // Sequencer state: waiting for a sample, or stepping through taps.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MAC  = 1'b1
    } fir_state_t;

    // Index width for a count n, never below one bit.
    function automatic int bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_fir_coef_bank.sv
// Coefficient register bank with an address/data write port and one
// combinational read port.
// Assumes: the read index is always below N; writes at index >= N are dropped.
module tdm_fir_coef_bank #(
    parameter int N  = 8,
    parameter int CW = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [tdm_fir_pkg::bits(N):0]       waddr,
    input  logic signed [CW-1:0]                wdata,
    input  logic [tdm_fir_pkg::bits(N)-1:0]     raddr,
    output logic signed [CW-1:0]                rdata
);
    localparam int IW  = tdm_fir_pkg::bits(N);
    localparam int CAW = IW + 1;

    logic [N*CW-1:0] flat;

    for (genvar i = 0; i < N; i++) begin : g_tap
        logic signed [CW-1:0] coef_r;
        // Hold coefficient i; load it when the write address matches.
        always_ff @(posedge clk) begin
            if (!rst_n)
                coef_r <= '0;
            else if (we && waddr == CAW'(i))
                coef_r <= wdata;
        end
        assign flat[i*CW +: CW] = coef_r;
    end

    assign rdata = $signed(flat[int'(raddr)*CW +: CW]);

endmodule

// File: rtl/tdm_fir_hist.sv
// Per-channel delay history. Each channel owns P slots and a circular
// write pointer, which moves only when that channel takes a sample.
// Assumes: wr_chan and rd_chan are below C, and rd_slot is below P.
module tdm_fir_hist #(
    parameter int C  = 4,
    parameter int P  = 4,
    parameter int DW = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [tdm_fir_pkg::bits(C)-1:0]     wr_chan,
    input  logic signed [DW-1:0]                wr_data,
    output logic [tdm_fir_pkg::bits(P)-1:0]     wr_slot,
    input  logic [tdm_fir_pkg::bits(C)-1:0]     rd_chan,
    input  logic [tdm_fir_pkg::bits(P)-1:0]     rd_slot,
    output logic signed [DW-1:0]                rd_data
);
    localparam int CHW   = tdm_fir_pkg::bits(C);
    localparam int PW    = tdm_fir_pkg::bits(P);
    localparam int DEPTH = C * P;
    localparam int MW    = tdm_fir_pkg::bits(DEPTH);

    logic signed [DW-1:0] mem [DEPTH];
    logic [PW-1:0]        wptr [C];
    logic [MW-1:0]        wr_idx, rd_idx;

    assign wr_slot = wptr[wr_chan];
    assign wr_idx  = MW'(int'(wr_chan) * P + int'(wptr[wr_chan]));
    assign rd_idx  = MW'(int'(rd_chan) * P + int'(rd_slot));
    assign rd_data = mem[rd_idx];

    // Advance the write pointer of the channel being written, wrapping at P.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < C; ch++) wptr[ch] <= '0;
        end else begin
            for (int ch = 0; ch < C; ch++)
                if (wr_en && wr_chan == CHW'(ch))
                    wptr[ch] <= (wptr[ch] == PW'(P - 1)) ? '0 : wptr[ch] + PW'(1);
        end
    end

    // Store the incoming sample in its channel's current slot; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/tdm_fir_round_sat.sv
// Rounds a wide accumulator half-up by dropping SH fraction bits, then
// saturates the result to a DW-bit signed value.
// Assumes: AW leaves headroom for the rounding bias and SH >= 1.
module tdm_fir_round_sat #(
    parameter int AW = 37,
    parameter int DW = 16,
    parameter int SH = 15
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [DW-1:0] res
);
    logic signed [AW-1:0] bias, shifted, maxv, minv;

    // Add half an LSB, shift down, then clamp to the output range.
    always_comb begin
        bias          = '0;
        bias[SH-1]    = 1'b1;
        shifted       = (acc + bias) >>> SH;
        maxv          = '0;
        maxv[DW-2:0]  = '1;
        minv          = '1;
        minv[DW-2:0]  = '0;
        if (shifted > maxv)
            res = maxv[DW-1:0];
        else if (shifted < minv)
            res = minv[DW-1:0];
        else
            res = shifted[DW-1:0];
    end

endmodule

// File: rtl/tdm_interp_fir.sv
// Time-shared polyphase interpolating FIR. It takes one sample of any
// channel, then spends P cycles on each of the L phases, one tap per cycle,
// and emits one rounded output per phase.
// Assumes: N is a multiple of L, P = N/L >= 2, and in_chan < C.
module tdm_interp_fir #(
    parameter int C  = 4,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int L  = 2,
    parameter int N  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [tdm_fir_pkg::bits(C)-1:0]     in_chan,
    input  logic signed [DW-1:0]                in_data,
    input  logic                                coef_we,
    input  logic [tdm_fir_pkg::bits(N):0]       coef_addr,
    input  logic signed [CW-1:0]                coef_data,
    output logic                                out_valid,
    output logic [tdm_fir_pkg::bits(C)-1:0]     out_chan,
    output logic [tdm_fir_pkg::bits(L)-1:0]     out_phase,
    output logic signed [DW-1:0]                out_data
);
    import tdm_fir_pkg::*;

    localparam int P    = N / L;
    localparam int CHW  = bits(C);
    localparam int PHW  = bits(L);
    localparam int PW   = bits(P);
    localparam int IW   = bits(N);
    localparam int PRW  = DW + CW;
    localparam int ACCW = PRW + PW + 1;

    fir_state_t             state_q;
    logic [CHW-1:0]         chan_q;
    logic [PW-1:0]          base_q, tap_q, base_w, rd_slot;
    logic [PHW-1:0]         phase_q;
    logic signed [ACCW-1:0] acc_q, sum_w;
    logic [IW-1:0]          coef_ra;
    logic signed [CW-1:0]   coef_rd;
    logic signed [DW-1:0]   hist_rd, rnd_w;
    logic signed [PRW-1:0]  prod_w;
    logic                   accept;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    tdm_fir_coef_bank #(.N(N), .CW(CW)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (coef_ra),
        .rdata (coef_rd)
    );

    tdm_fir_hist #(.C(C), .P(P), .DW(DW)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_chan (in_chan),
        .wr_data (in_data),
        .wr_slot (base_w),
        .rd_chan (chan_q),
        .rd_slot (rd_slot),
        .rd_data (hist_rd)
    );

    tdm_fir_round_sat #(.AW(ACCW), .DW(DW), .SH(CW - 1)) u_rnd (
        .acc (sum_w),
        .res (rnd_w)
    );

    // Pick the history slot of sample n-tap and the coefficient phase+tap*L.
    always_comb begin
        int slot_i;
        int cidx_i;
        slot_i = int'(base_q) - int'(tap_q);
        if (slot_i < 0) slot_i = slot_i + P;
        rd_slot = PW'(slot_i);
        cidx_i  = int'(phase_q) + int'(tap_q) * L;
        coef_ra = IW'(cidx_i);
    end

    // One full-precision product per cycle, added to the running sum.
    assign prod_w = $signed({{CW{hist_rd[DW-1]}}, hist_rd}) *
                    $signed({{DW{coef_rd[CW-1]}}, coef_rd});
    assign sum_w  = acc_q + {{(ACCW - PRW){prod_w[PRW-1]}}, prod_w};

    // Sequencer: take a sample, walk P taps for each of L phases, emit outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            chan_q    <= '0;
            base_q    <= '0;
            tap_q     <= '0;
            phase_q   <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_phase <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        chan_q  <= in_chan;
                        base_q  <= base_w;
                        tap_q   <= '0;
                        phase_q <= '0;
                        acc_q   <= '0;
                        state_q <= ST_MAC;
                    end
                end
                ST_MAC: begin
                    if (tap_q == PW'(P - 1)) begin
                        out_valid <= 1'b1;
                        out_data  <= rnd_w;
                        out_chan  <= chan_q;
                        out_phase <= phase_q;
                        acc_q     <= '0;
                        tap_q     <= '0;
                        if (phase_q == PHW'(L - 1))
                            state_q <= ST_IDLE;
                        else
                            phase_q <= phase_q + PHW'(1);
                    end else begin
                        acc_q <= sum_w;
                        tap_q <= tap_q + PW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tdm_interp_fir_chk.sv
// Protocol checker for tdm_interp_fir, attached with bind. It tracks the
// channel of the last accepted sample, the outputs seen since then and the
// length of the busy window.
// Assumes: in_chan < C.
module tdm_interp_fir_chk #(
    parameter int C = 4,
    parameter int L = 2,
    parameter int N = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                in_valid,
    input logic                                in_ready,
    input logic [tdm_fir_pkg::bits(C)-1:0]     in_chan,
    input logic                                out_valid,
    input logic [tdm_fir_pkg::bits(C)-1:0]     out_chan,
    input logic [tdm_fir_pkg::bits(L)-1:0]     out_phase
);
    localparam int P   = N / L;
    localparam int LP  = L * P;
    localparam int CHW = tdm_fir_pkg::bits(C);
    localparam int PHW = tdm_fir_pkg::bits(L);

    logic           accept;
    logic           seen;
    logic [CHW-1:0] lat_chan;
    int             out_cnt;
    int             busy_cnt;

    assign accept = in_valid && in_ready;

    // Track the last accepted channel, outputs since then and busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            lat_chan <= '0;
            out_cnt  <= 0;
            busy_cnt <= 0;
        end else if (accept) begin
            seen     <= 1'b1;
            lat_chan <= in_chan;
            out_cnt  <= 0;
            busy_cnt <= 1;
        end else begin
            if (out_valid) out_cnt <= out_cnt + 1;
            if (!in_ready) busy_cnt <= busy_cnt + 1;
        end
    end

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R6
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (busy_cnt >= 1 && busy_cnt <= LP));

    // R2
    out_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_chan == lat_chan);

    // R2
    out_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_phase == PHW'(out_cnt));

    // R2
    out_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && seen) |-> (out_cnt + int'(out_valid)) == L);

    // R9
    out_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!in_ready));

    // R8
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (in_ready && !out_valid));

endmodule

bind tdm_interp_fir tdm_interp_fir_chk #(.C(C), .L(L), .N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_chan   (in_chan),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_phase (out_phase)
);

// File: tb/tdm_interp_fir_tb.sv
// Self-checking bench: a stimulus table walked by one loop, then directed
// tests for rounding, saturation, busy-window pulses, coefficient writes
// and reset. Expected values come from a behavioural model of the requirements.
module tdm_interp_fir_tb;
    import tdm_fir_pkg::*;

    localparam int C   = 4;
    localparam int DW  = 16;
    localparam int CW  = 16;
    localparam int L   = 2;
    localparam int N   = 8;
    localparam int P   = N / L;
    localparam int LP  = L * P;
    localparam int CHW = bits(C);
    localparam int PHW = bits(L);
    localparam int CAW = bits(N) + 1;
    localparam int NV  = 12;

    // Stimulus table: {channel, sample}, with channels interleaved.
    localparam logic [CHW+DW-1:0] STIM [NV] = '{
        {2'd0,  16'sd1200}, {2'd1, -16'sd2500}, {2'd0,  16'sd3000},
        {2'd2,  16'sd32000}, {2'd0, -16'sd7000}, {2'd1,  16'sd4100},
        {2'd3, -16'sd32768}, {2'd0,  16'sd555}, {2'd2, -16'sd1234},
        {2'd1,  16'sd20000}, {2'd3,  16'sd8191}, {2'd0,  16'sd0}
    };

    localparam int CF [N] = '{8192, -4096, 16384, 2048, -8192, 1024, 4096, -2048};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [CHW-1:0]       in_chan = '0;
    logic signed [DW-1:0] in_data = '0;
    logic                 coef_we = 1'b0;
    logic [CAW-1:0]       coef_addr = '0;
    logic signed [CW-1:0] coef_data = '0;
    logic                 out_valid;
    logic [CHW-1:0]       out_chan;
    logic [PHW-1:0]       out_phase;
    logic signed [DW-1:0] out_data;

    int     checks = 0;
    int     errors = 0;
    int     coef_m [N];
    longint hist_m [C][P];

    always #5 clk = ~clk;

    tdm_interp_fir #(.C(C), .DW(DW), .CW(CW), .L(L), .N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_chan   (in_chan),
        .in_data   (in_data),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_phase (out_phase),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < N; i++) coef_m[i] = 0;
        for (int c = 0; c < C; c++)
            for (int k = 0; k < P; k++) hist_m[c][k] = 0;
    endtask

    // Expected output from R1, R4 and R5.
    function automatic longint model_out(input int ch, input int p);
        longint acc  = 0;
        longint r;
        longint maxv = (longint'(1) <<< (DW - 1)) - 1;
        longint minv = -(longint'(1) <<< (DW - 1));
        for (int k = 0; k < P; k++)
            acc += longint'(coef_m[p + k * L]) * hist_m[ch][k];
        r = (acc + (longint'(1) <<< (CW - 2))) >>> (CW - 1);
        if (r > maxv) r = maxv;
        if (r < minv) r = minv;
        return r;
    endfunction

    task automatic write_coef(input int addr, input int val);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = CAW'(addr);
        coef_data = CW'(val);
        @(negedge clk);
        coef_we = 1'b0;
        if (addr < N) coef_m[addr] = val;
    endtask

    // Send one sample and follow it cycle by cycle until in_ready returns.
    // With noise set, drive in_valid with junk whenever in_ready is low.
    task automatic run_sample(input int ch, input int d, input bit noise, input string req);
        longint exp_v [L];
        @(negedge clk);
        check(in_ready == 1'b1, "R6", "ready before sample", longint'(in_ready), 1);
        in_valid = 1'b1;
        in_chan  = CHW'(ch);
        in_data  = DW'(d);
        for (int k = P - 1; k > 0; k--) hist_m[ch][k] = hist_m[ch][k-1];
        hist_m[ch][0] = d;
        for (int p = 0; p < L; p++) exp_v[p] = model_out(ch, p);
        for (int j = 1; j <= LP + 1; j++) begin
            @(negedge clk);
            if (j > 1 && (j - 1) % P == 0) begin
                int p = (j - 1) / P - 1;
                check(out_valid == 1'b1, "R9", "output strobe", longint'(out_valid), 1);
                check(out_chan == CHW'(ch), "R2", "output channel", longint'(out_chan), ch);
                check(out_phase == PHW'(p), "R2", "output phase", longint'(out_phase), p);
                check(longint'(out_data) == exp_v[p], req, "output data",
                      longint'(out_data), exp_v[p]);
            end else begin
                check(out_valid == 1'b0, "R9", "no output", longint'(out_valid), 0);
            end
            check(in_ready == (j == LP + 1), "R6", "ready window",
                  longint'(in_ready), longint'(j == LP + 1));
            if (noise && !in_ready) begin
                in_valid = 1'b1;
                in_data  = DW'(7000 + 13 * j);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R8: state held in reset
        check(in_ready == 1'b1, "R8", "ready in reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R8", "valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;

        // R7: load the taps, then write two out-of-range indices
        for (int i = 0; i < N; i++) write_coef(i, CF[i]);
        write_coef(N, 30000);
        write_coef(2 * N - 1, -30000);

        // R1 R3: table walk over interleaved channels
        for (int i = 0; i < NV; i++)
            run_sample(int'(STIM[i][CHW+DW-1:DW]), int'($signed(STIM[i][DW-1:0])), 1'b0, "R1 R3");

        // R7: rewriting one tap changes later results
        write_coef(1, 12000);
        run_sample(1, 9000, 1'b0, "R7");

        // R6: junk pulses during the busy window must not enter the history
        run_sample(2, 500, 1'b1, "R6");
        run_sample(2, -700, 1'b0, "R6");

        // R4: a single unit tap exposes the half-LSB rounding
        for (int i = 0; i < N; i++) write_coef(i, (i == 0) ? 1 : 0);
        run_sample(3, 16384, 1'b0, "R4");
        run_sample(3, -16384, 1'b0, "R4");
        run_sample(3, -16385, 1'b0, "R4");
        run_sample(3, 16383, 1'b0, "R4");

        // R5: full-scale taps drive the sum past both limits
        for (int i = 0; i < N; i++) write_coef(i, (i % L == 0) ? 32767 : 0);
        for (int i = 0; i < P; i++) run_sample(0, 32767, 1'b0, "R5");
        for (int i = 0; i < P; i++) run_sample(0, -32768, 1'b0, "R5");

        // R8: reset in the middle of a computation
        @(negedge clk);
        in_valid = 1'b1;
        in_chan  = CHW'(1);
        in_data  = DW'(9000);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "ready during reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R8", "valid during reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        clear_model();
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "ready after reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R8", "valid after reset", longint'(out_valid), 0);
        run_sample(1, 20000, 1'b0, "R8");
        for (int i = 0; i < N; i++) write_coef(i, CF[i]);
        run_sample(1, 3000, 1'b0, "R8");
        run_sample(0, -3000, 1'b0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule